// File: doc/BRIEF.md
# Windowed SAD Block-Matching Search Unit

The unit takes the current video frame as a raster-ordered pixel stream, one pixel per accepted clock. It pairs each stored feature of the previous frame with the position in the current frame whose square window is most similar to the feature's window. The similarity measure is the sum of absolute differences (SAD). The frame is split into horizontal bands of equal height, one band per feature, and a single matcher is reused band after band. This relies on small motion between frames: the feature belonging to band k is searched for only inside band k of the current frame, so a feature close to a band edge may go unmatched.

Line buffers build a moving W×W window over the incoming pixels. A position is named by the raster address of its window's bottom-right pixel, packed as {row, col}; a feature address uses the same convention. For each band, a small fetch engine reads the feature's W×W reference window from a previous-frame memory port. It first reads the feature address from a feature-bank read port. The window goes into a staging copy while the band before is still being searched, and that copy becomes the active reference when the stream enters the band.

Every accepted pixel produces one SAD, two stages later. A running-minimum register keeps the smallest SAD seen in the band together with its address. When the band's last pixel has been compared, the unit emits a one-cycle result carrying the band index, the best address and its SAD.

The fetch engine is a four-state machine:
- **IDLE** waits for a start-of-frame pixel. The transition IDLE→FETCH happens when that pixel is accepted.
- **FETCH** issues W·W reads in row-major order over the reference window. FETCH→DRAIN happens after the last read is issued.
- **DRAIN** stores the last returned word. DRAIN→ARMED happens unconditionally.
- **ARMED** holds the staged window until the first accepted pixel of the pending band. At that pixel the staged window becomes active. ARMED then goes to FETCH for the next band, or to IDLE after the last band.

From any state, an accepted start-of-frame pixel restarts the engine in FETCH for band 0.

Top module: `sadm_search`

## Requirements
- R1: While reset is asserted and afterwards until the first start-of-frame pixel, `res_vld` and `ref_rd` stay low.
- R2: Each complete frame gives exactly NREG result pulses, one cycle each, with `res_region` counting 0, 1, … in band order. Band k's pulse is visible two clock edges after the edge that accepts the band's last pixel (row k·BAND+BAND−1, column DIM−1).
- R3: `res_addr` is the packed {row, col} (row in the upper CW bits) of the window's bottom-right pixel for the best candidate. The candidates are the positions whose row lies in the band, whose row is at least W−1 and whose column is at least W−1.
- R4: `res_sad` equals the sum over all W×W pixel pairs of |current − reference|, where the reference window's bottom-right pixel is at the feature address. The range is 0 to W·W·31 (1116 for W = 6).
- R5: A candidate replaces the running minimum only when its SAD is strictly smaller. Among equal SADs, the earliest raster position wins.
- R6: The running minimum restarts at every band, so a band's result does not depend on SADs from earlier bands.
- R7: Cycles with `pix_vld` low advance nothing: results are identical whatever idle cycles are inserted between pixels.
- R8: Per frame, the unit issues exactly NREG·W·W reads on the previous-frame port (`ref_rd` high, data returned on `ref_data` one cycle later). The addresses walk the reference window row by row from its top-left pixel, and no two consecutive reads use the same address.
- R9: The feature for band k is read from the bank port with `feat_idx` = k, which stays unchanged while that band's reads are in progress.
- R10: An accepted pixel with `pix_sof` high is raster address 0 and restarts the search. An abandoned partial frame that completes no band produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_vld | input | 1 | Current-frame pixel present this cycle |
| pix_sof | input | 1 | Marks the first pixel of a frame |
| pix_data | input | PW | Current-frame pixel value |
| feat_idx | output | RIW | Band index presented to the feature bank |
| feat_addr | input | 2·CW | Feature address {row, col} returned by the bank |
| ref_rd | output | 1 | Read strobe to the previous-frame memory |
| ref_addr | output | 2·CW | Previous-frame read address {row, col} |
| ref_data | input | PW | Previous-frame read data, one cycle after the strobe |
| res_vld | output | 1 | One-cycle result pulse per band |
| res_region | output | RIW | Band index of the result |
| res_addr | output | 2·CW | Best-match address {row, col} |
| res_sad | output | SW | SAD of the best match |

## Verification
The bench goes after ties on a uniform frame. A comparator using less-or-equal there would report the last position of each band instead of the first (addresses 85 and 133). It checks the SAD ceiling with an all-31 reference against an all-zero frame. A minimum register initialised below 1116 would never capture a candidate. It checks a frame where band 0 matches exactly and band 1 is inverted. A minimum not restarted per band would carry the zero from band 0 into band 1's answer. It also checks idle gaps in the stream and an abandoned half frame. A design that advanced its window on idle cycles, or did not restart on a new frame, would report shifted addresses or spurious results.

// File: rtl/sadm_pkg.sv
package sadm_pkg;

    // Reference fetch engine states.
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DRAIN,
        ST_ARMED
    } fetch_st_t;

endpackage

// File: rtl/sadm_window.sv
// Line buffers plus a W x W window register whose bottom-right cell is the
// most recently accepted pixel.
module sadm_window #(
    parameter int PW  = 5,
    parameter int DIM = 16,
    parameter int W   = 6,
    localparam int DLEN = (W - 1) * DIM,
    localparam int WV   = W * W * PW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc,
    input  logic [PW-1:0] pix,
    output logic [WV-1:0] win_flat
);

    logic [PW-1:0] dl  [DLEN];
    logic [PW-1:0] win [W][W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DLEN; k++) dl[k] <= '0;
            for (int r = 0; r < W; r++)
                for (int c = 0; c < W; c++) win[r][c] <= '0;
        end else if (acc) begin
            dl[0] <= pix;
            for (int k = 1; k < DLEN; k++) dl[k] <= dl[k-1];
            for (int r = 0; r < W; r++)
                for (int c = 0; c < W - 1; c++) win[r][c] <= win[r][c+1];
            for (int r = 0; r < W - 1; r++) win[r][W-1] <= dl[(W-1-r)*DIM-1];
            win[W-1][W-1] <= pix;
        end
    end

    for (genvar gr = 0; gr < W; gr++) begin : g_row
        for (genvar gc = 0; gc < W; gc++) begin : g_col
            assign win_flat[(gr*W+gc)*PW +: PW] = win[gr][gc];
        end
    end

endmodule

// File: rtl/sadm_sad_tree.sv
// Sum of absolute differences over two flattened W x W windows.
module sadm_sad_tree #(
    parameter int PW = 5,
    parameter int WW = 36,
    parameter int SW = 11
) (
    input  logic [WW*PW-1:0] cur_flat,
    input  logic [WW*PW-1:0] ref_flat,
    output logic [SW-1:0]    sad
);

    logic [PW-1:0] ad [WW];

    for (genvar g = 0; g < WW; g++) begin : g_ad
        logic [PW-1:0] a, b;
        assign a     = cur_flat[g*PW +: PW];
        assign b     = ref_flat[g*PW +: PW];
        assign ad[g] = (a > b) ? (a - b) : (b - a);
    end

    always_comb begin
        sad = '0;
        for (int i = 0; i < WW; i++) sad = sad + SW'(ad[i]);
    end

endmodule

// File: rtl/sadm_ref_fetch.sv
// Fetches the reference window of the pending band into a staging copy and
// promotes it to the active copy when the stream enters that band.
module sadm_ref_fetch
    import sadm_pkg::*;
#(
    parameter int PW   = 5,
    parameter int W    = 6,
    parameter int CW   = 4,
    parameter int NREG = 2,
    parameter int RIW  = 1,
    localparam int WW  = W * W,
    localparam int WIW = $clog2(WW),
    localparam int CIW = $clog2(W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc,
    input  logic             sof,
    input  logic [RIW-1:0]   acc_band,
    input  logic [2*CW-1:0]  feat_addr,
    output logic [RIW-1:0]   feat_idx,
    output logic             ref_rd,
    output logic [2*CW-1:0]  ref_addr,
    input  logic [PW-1:0]    ref_data,
    output logic [WW*PW-1:0] act_flat
);

    localparam logic [CW-1:0] OFF = CW'(W - 1);

    fetch_st_t      st, nst;
    logic [RIW-1:0] pend;
    logic [CIW-1:0] fi, fj;
    logic           rd_q;
    logic [WIW-1:0] widx_q;
    logic [PW-1:0]  nxt [WW];
    logic [PW-1:0]  act [WW];
    logic           copy, last_issue, restart;

    assign restart    = acc && sof;
    assign copy       = (st == ST_ARMED) && acc && !sof && (acc_band == pend);
    assign last_issue = (st == ST_FETCH) && (fi == CIW'(W - 1)) && (fj == CIW'(W - 1));

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nst;
    end

    // Transitions.
    always_comb begin
        nst = st;
        if (restart) begin
            nst = ST_FETCH;
        end else begin
            unique case (st)
                ST_IDLE:  nst = ST_IDLE;
                ST_FETCH: if (last_issue) nst = ST_DRAIN;
                ST_DRAIN: nst = ST_ARMED;
                ST_ARMED: if (copy) nst = (pend == RIW'(NREG - 1)) ? ST_IDLE : ST_FETCH;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        ref_rd   = (st == ST_FETCH);
        feat_idx = pend;
        ref_addr = {feat_addr[2*CW-1:CW] - OFF + CW'(fi),
                    feat_addr[CW-1:0]    - OFF + CW'(fj)};
    end

    // Counters and window storage.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend   <= '0;
            fi     <= '0;
            fj     <= '0;
            rd_q   <= 1'b0;
            widx_q <= '0;
            for (int k = 0; k < WW; k++) begin
                nxt[k] <= '0;
                act[k] <= '0;
            end
        end else begin
            rd_q   <= ref_rd;
            widx_q <= WIW'(fi) * WIW'(W) + WIW'(fj);
            if (rd_q) nxt[widx_q] <= ref_data;
            if (restart) begin
                pend <= '0;
                fi   <= '0;
                fj   <= '0;
            end else if (st == ST_FETCH) begin
                if (fj == CIW'(W - 1)) begin
                    fj <= '0;
                    fi <= fi + CIW'(1);
                end else begin
                    fj <= fj + CIW'(1);
                end
            end else if (copy) begin
                for (int k = 0; k < WW; k++) act[k] <= nxt[k];
                pend <= pend + RIW'(1);
                fi   <= '0;
                fj   <= '0;
            end
        end
    end

    for (genvar g = 0; g < WW; g++) begin : g_act
        assign act_flat[g*PW +: PW] = act[g];
    end

endmodule

// File: rtl/sadm_search.sv
// Windowed SAD block-matching search unit (top).
module sadm_search #(
    parameter int PW   = 5,
    parameter int DIM  = 16,
    parameter int BAND = 8,
    parameter int W    = 6,
    localparam int CW   = $clog2(DIM),
    localparam int AW   = 2 * CW,
    localparam int NREG = DIM / BAND,
    localparam int RIW  = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int WW   = W * W,
    localparam int SW   = $clog2(WW * ((1 << PW) - 1) + 1),
    localparam int WV   = WW * PW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pix_vld,
    input  logic           pix_sof,
    input  logic [PW-1:0]  pix_data,
    output logic [RIW-1:0] feat_idx,
    input  logic [AW-1:0]  feat_addr,
    output logic           ref_rd,
    output logic [AW-1:0]  ref_addr,
    input  logic [PW-1:0]  ref_data,
    output logic           res_vld,
    output logic [RIW-1:0] res_region,
    output logic [AW-1:0]  res_addr,
    output logic [SW-1:0]  res_sad
);

    // Position of the pixel being accepted.
    logic [AW-1:0]  pos_q, idx;
    logic [CW-1:0]  row, col;
    logic [RIW-1:0] band;
    logic           in_win, band_end;

    always_comb begin
        idx      = pix_sof ? '0 : pos_q;
        row      = idx[AW-1:CW];
        col      = idx[CW-1:0];
        band     = RIW'(int'(row) / BAND);
        in_win   = (int'(row) >= W - 1) && (int'(col) >= W - 1);
        band_end = (int'(col) == DIM - 1) && ((int'(row) % BAND) == BAND - 1);
    end

    logic [WV-1:0] win_flat, act_flat;
    logic [SW-1:0] sad_c;

    sadm_window #(.PW(PW), .DIM(DIM), .W(W)) u_window (
        .clk(clk), .rst_n(rst_n), .acc(pix_vld), .pix(pix_data), .win_flat(win_flat)
    );

    sadm_ref_fetch #(.PW(PW), .W(W), .CW(CW), .NREG(NREG), .RIW(RIW)) u_fetch (
        .clk(clk), .rst_n(rst_n), .acc(pix_vld), .sof(pix_sof), .acc_band(band),
        .feat_addr(feat_addr), .feat_idx(feat_idx), .ref_rd(ref_rd),
        .ref_addr(ref_addr), .ref_data(ref_data), .act_flat(act_flat)
    );

    sadm_sad_tree #(.PW(PW), .WW(WW), .SW(SW)) u_tree (
        .cur_flat(win_flat), .ref_flat(act_flat), .sad(sad_c)
    );

    // Stage 0: tag of the window just loaded. Stage 1: registered SAD.
    logic           s0_vld, s0_sof, s0_cmp, s0_last;
    logic [RIW-1:0] s0_band;
    logic [AW-1:0]  s0_idx;
    logic           s1_vld, s1_sof, s1_cmp, s1_last;
    logic [RIW-1:0] s1_band;
    logic [AW-1:0]  s1_idx;
    logic [SW-1:0]  s1_sad;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q   <= '0;
            s0_vld  <= 1'b0; s0_sof <= 1'b0; s0_cmp <= 1'b0; s0_last <= 1'b0;
            s0_band <= '0;   s0_idx <= '0;
            s1_vld  <= 1'b0; s1_sof <= 1'b0; s1_cmp <= 1'b0; s1_last <= 1'b0;
            s1_band <= '0;   s1_idx <= '0;   s1_sad <= '0;
        end else begin
            if (pix_vld) pos_q <= idx + AW'(1);
            s0_vld  <= pix_vld;
            s0_sof  <= pix_vld && pix_sof;
            s0_cmp  <= pix_vld && in_win;
            s0_last <= pix_vld && band_end;
            s0_band <= band;
            s0_idx  <= idx;
            s1_vld  <= s0_vld;
            s1_sof  <= s0_sof;
            s1_cmp  <= s0_cmp;
            s1_last <= s0_last;
            s1_band <= s0_band;
            s1_idx  <= s0_idx;
            s1_sad  <= sad_c;
        end
    end

    // Stage 2: running minimum, strict comparison keeps the earliest tie.
    logic [SW-1:0] min_q, min_n;
    logic [AW-1:0] ck_q, ck_n;
    logic          better;

    always_comb begin
        better = s1_cmp && (s1_sad < min_q);
        min_n  = better ? s1_sad : min_q;
        ck_n   = better ? s1_idx : ck_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            min_q      <= '1;
            ck_q       <= '0;
            res_vld    <= 1'b0;
            res_region <= '0;
            res_addr   <= '0;
            res_sad    <= '0;
        end else begin
            res_vld <= 1'b0;
            if (s1_vld) begin
                if (s1_last) begin
                    res_vld    <= 1'b1;
                    res_region <= s1_band;
                    res_addr   <= ck_n;
                    res_sad    <= min_n;
                    min_q      <= '1;
                    ck_q       <= '0;
                end else if (s1_sof) begin
                    min_q <= '1;
                    ck_q  <= '0;
                end else begin
                    min_q <= min_n;
                    ck_q  <= ck_n;
                end
            end
        end
    end

endmodule

// File: rtl/sadm_search_chk.sv
module sadm_search_chk #(
    parameter int AW      = 8,
    parameter int RIW     = 1,
    parameter int SW      = 11,
    parameter int SAD_MAX = 1116
) (
    input logic           clk,
    input logic           rst_n,
    input logic           res_vld,
    input logic           ref_rd,
    input logic [RIW-1:0] feat_idx,
    input logic [AW-1:0]  ref_addr,
    input logic [SW-1:0]  res_sad
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!res_vld && !ref_rd));

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |=> !res_vld);

    // R4
    sad_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> (res_sad <= SW'(SAD_MAX)));

    // R9
    feat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_rd && $past(ref_rd)) |-> $stable(feat_idx));

    // R8
    ref_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_rd && $past(ref_rd)) |-> (ref_addr != $past(ref_addr)));

endmodule

bind sadm_search sadm_search_chk #(
    .AW(AW), .RIW(RIW), .SW(SW), .SAD_MAX(WW * ((1 << PW) - 1))
) u_chk (
    .clk(clk), .rst_n(rst_n), .res_vld(res_vld), .ref_rd(ref_rd),
    .feat_idx(feat_idx), .ref_addr(ref_addr), .res_sad(res_sad)
);

// File: tb/sadm_search_bench.sv
module sadm_search_bench;

    localparam int CLK_NS = 10;
    localparam int PW   = 5;
    localparam int DIM  = 16;
    localparam int BAND = 8;
    localparam int W    = 6;
    localparam int NREG = DIM / BAND;
    localparam int NPIX = DIM * DIM;
    localparam int BPIX = BAND * DIM;
    localparam int AW   = 8;
    localparam int SW   = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pix_vld = 1'b0;
    logic          pix_sof = 1'b0;
    logic [PW-1:0] pix_data = '0;
    logic [0:0]    feat_idx;
    logic [AW-1:0] feat_addr;
    logic          ref_rd;
    logic [AW-1:0] ref_addr;
    logic [PW-1:0] ref_data;
    logic          res_vld;
    logic [0:0]    res_region;
    logic [AW-1:0] res_addr;
    logic [SW-1:0] res_sad;

    int prv [NPIX];
    int cur [NPIX];
    int feat [NREG];
    int cyc = 0, rd_cnt = 0, nres = 0, fb = 0;
    int g_reg [64], g_addr [64], g_sad [64], g_cyc [64];
    int lastcyc [NREG];
    int keep_addr [NREG];
    int total = 0, bad = 0;
    int seed = 12345;

    sadm_search u_sadm_search (
        .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .pix_sof(pix_sof),
        .pix_data(pix_data), .feat_idx(feat_idx), .feat_addr(feat_addr),
        .ref_rd(ref_rd), .ref_addr(ref_addr), .ref_data(ref_data),
        .res_vld(res_vld), .res_region(res_region), .res_addr(res_addr),
        .res_sad(res_sad)
    );

    always #(CLK_NS / 2) clk = ~clk;

    assign feat_addr = AW'(feat[feat_idx]);

    // Previous-frame memory model, one cycle read latency.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (ref_rd) begin
            ref_data <= PW'(prv[ref_addr]);
            rd_cnt   <= rd_cnt + 1;
        end
    end

    always @(negedge clk) begin
        if (res_vld) begin
            g_reg[nres % 64]  = int'(res_region);
            g_addr[nres % 64] = int'(res_addr);
            g_sad[nres % 64]  = int'(res_sad);
            g_cyc[nres % 64]  = cyc;
            nres = nres + 1;
        end
    end

    initial begin
        #(CLK_NS * 150000);
        total = total + 1;
        bad   = bad + 1;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic int nextr();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 16) & 31;
    endfunction

    function automatic int absd(int a, int b);
        return (a > b) ? a - b : b - a;
    endfunction

    // SAD of the candidate ending at br against feature k's window.
    function automatic int msad(int k, int br);
        int fr = feat[k] / DIM, fc = feat[k] % DIM;
        int r = br / DIM, c = br % DIM, s = 0;
        for (int i = 0; i < W; i++)
            for (int j = 0; j < W; j++)
                s += absd(cur[(r-W+1+i)*DIM + c-W+1+j],
                          prv[(fr-W+1+i)*DIM + fc-W+1+j]);
        return s;
    endfunction

    task automatic mbest(input int k, output int ba, output int bs);
        bs = 1 << 30;
        ba = 0;
        for (int r = k * BAND; r < k * BAND + BAND; r++)
            if (r >= W - 1)
                for (int c = W - 1; c < DIM; c++)
                    if (msad(k, r*DIM + c) < bs) begin
                        bs = msad(k, r*DIM + c);
                        ba = r*DIM + c;
                    end
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input int gap, input int npix);
        for (int p = 0; p < npix; p++) begin
            @(negedge clk);
            pix_vld  = 1'b1;
            pix_sof  = (p == 0);
            pix_data = PW'(cur[p]);
            if (p % BPIX == BPIX - 1) lastcyc[p / BPIX] = cyc;
            if (gap > 0 && p % gap == gap - 1) begin
                @(negedge clk);
                pix_vld = 1'b0;
                pix_sof = 1'b0;
            end
        end
        @(negedge clk);
        pix_vld = 1'b0;
        pix_sof = 1'b0;
    endtask

    task automatic frame(input string name, input int gap);
        int b0 = nres, r0 = rd_cnt, ba, bs;
        fb = b0;
        drive(gap, NPIX);
        repeat (6) @(negedge clk);
        chk("R2", {name, " result count"}, nres - b0, NREG);
        chk("R8", {name, " reference reads"}, rd_cnt - r0, NREG * W * W);
        for (int k = 0; k < NREG; k++) begin
            mbest(k, ba, bs);
            chk("R2", {name, " band order"}, g_reg[(b0+k) % 64], k);
            chk("R3", {name, " best address"}, g_addr[(b0+k) % 64], ba);
            chk("R4 R9", {name, " best sad"}, g_sad[(b0+k) % 64], bs);
            chk("R2", {name, " latency"}, g_cyc[(b0+k) % 64] - lastcyc[k], 3);
        end
    endtask

    initial begin
        int b;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "res_vld in reset", int'(res_vld), 0);
        chk("R1", "ref_rd in reset", int'(ref_rd), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "res_vld before frame", int'(res_vld), 0);
        chk("R1", "ref_rd before frame", int'(ref_rd), 0);

        // Shifted copy: exact match exists in each band.
        feat[0] = 6*DIM + 7;
        feat[1] = 11*DIM + 8;
        for (int p = 0; p < NPIX; p++) prv[p] = nextr();
        for (int r = 0; r < DIM; r++)
            for (int c = 0; c < DIM; c++)
                cur[r*DIM+c] = (r >= 1 && c >= 2) ? prv[(r-1)*DIM + c-2] : nextr();
        frame("shift", 0);
        chk("R4", "shift band0 sad", g_sad[fb % 64], 0);
        chk("R4", "shift band1 sad", g_sad[(fb+1) % 64], 0);

        // Independent random frames, continuous stream.
        feat[0] = 7*DIM + 15;
        feat[1] = 15*DIM + 5;
        for (int p = 0; p < NPIX; p++) begin
            prv[p] = nextr();
            cur[p] = nextr();
        end
        frame("random", 0);
        for (int k = 0; k < NREG; k++) keep_addr[k] = g_addr[(fb+k) % 64];

        // R7: same data with idle cycles inserted.
        frame("gapped", 3);
        for (int k = 0; k < NREG; k++)
            chk("R7", "gapped equals continuous", g_addr[(fb+k) % 64], keep_addr[k]);

        // R5: uniform frames, every SAD ties at zero.
        feat[0] = 6*DIM + 7;
        feat[1] = 11*DIM + 8;
        for (int p = 0; p < NPIX; p++) begin
            prv[p] = 9;
            cur[p] = 9;
        end
        frame("uniform", 0);
        chk("R5", "tie band0 earliest", g_addr[fb % 64], 5*DIM + 5);
        chk("R5", "tie band1 earliest", g_addr[(fb+1) % 64], 8*DIM + 5);

        // R4: largest SAD still captured.
        for (int p = 0; p < NPIX; p++) begin
            prv[p] = 31;
            cur[p] = 0;
        end
        frame("extreme", 2);
        chk("R4", "extreme sad", g_sad[fb % 64], W*W*31);
        chk("R5", "extreme first position", g_addr[fb % 64], 5*DIM + 5);

        // R6: band0 exact, band1 inverted; minimum must restart.
        for (int p = 0; p < NPIX; p++) begin
            prv[p] = nextr();
            cur[p] = (p < BPIX) ? prv[p] : 31 - prv[p];
        end
        frame("restart-min", 0);
        chk("R6", "band0 exact", g_sad[fb % 64], 0);
        chk("R6", "band1 not zero", int'(g_sad[(fb+1) % 64] == 0), 0);

        // R10: abandoned partial frame, then a full one.
        for (int p = 0; p < NPIX; p++) cur[p] = nextr();
        b = nres;
        drive(0, 100);
        repeat (6) @(negedge clk);
        chk("R10", "partial frame results", nres - b, 0);
        frame("after-abort", 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule